// File: doc/BRIEF.md
# Watchdog Timer Peripheral

This block is a bus-attached watchdog. Software programs a cycle count, clears the sticky expiry flag and turns the timer on. From then on it must rewrite the count periodically as a keep-alive. If the count is allowed to run down to zero, the block records the expiry in a status flag and emits a one-cycle interrupt pulse. It also raises a reset request, but only when a separate reset-enable register allows it.

The count decrements on prescaled ticks. The tick source is either every clock cycle or an external fixed-rate tick pulse, chosen by a control bit. A power-of-two ratio field then divides that source. The live count can be read back at any time, so software can work out the time remaining. The register bus accepts a write in a single cycle, honours byte-lane strobes, and returns read data one cycle after the read strobe.

Top module: `wdog_periph`

## Requirements
- R1: After reset the control word, status word and reset-enable word read 0, the count reads 0xFFFFFFFF, and irq and rst_req are low.
- R2: Register map: control at 0x00 (run = bit 8, tick-source select = bit 10, ratio = bits 19:16), status at 0x04 (expired = bit 31), reset-enable at 0x08 (enable = bit 8), count at 0x34. Other addresses and bits read 0. bus_rdata shows the addressed value as it stood in the cycle bus_rd was high, from the following cycle on.
- R3: A write changes only the byte lanes whose bus_wstrb bit is 1. The other bytes keep their value.
- R4: While run is 1 the count falls by exactly one per prescaled tick and never goes below 0. While run is 0 the count does not change except by a write.
- R5: With ratio N, one prescaled tick occurs for every 2^N source events. The divider restarts whenever run is 0.
- R6: With the tick-source bit at 0, every clock cycle is a source event. With it at 1, only cycles with fixed_tick high are source events.
- R7: A count write loads the new value. If a tick falls in the same cycle, the write takes precedence. Rewriting the count before it reaches 0 prevents expiry.
- R8: When a tick moves the count from 1 to 0, the expired flag sets and irq is high for exactly one cycle. The count then stays at 0.
- R9: The expired flag is sticky. Only a write to 0x04 with lane 3 enabled and bit 31 = 0 clears it, and writing 1 has no effect. An expiry in the same cycle as a clear leaves the flag set.
- R10: rst_req is high exactly while the expired flag, run and the reset-enable bit are all 1.
- R11: Loading a count of 0 and running does not produce an expiry or an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write enables |
| fixed_tick | input | 1 | Fixed-rate source event pulse |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| irq | output | 1 | One-cycle expiry pulse |
| rst_req | output | 1 | Reset request level |

## Verification
The hardest situation to reach is an expiry that lands in the same clock as a software clear of the expired flag. A two-count load followed by a run-enable write fixes the expiry edge exactly, and the bench then issues the status clear so that its write edge coincides with it. A second case that is hard to reach is the reset request appearing or vanishing purely through enable changes on an already-expired timer. The stimulus reaches it by toggling run and the reset-enable bit after an expiry, while the count sits at zero.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int BUS_W  = 32;
    localparam int STRB_W = BUS_W / 8;

    // register offsets (bytes)
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_STAT  = 'h04;
    localparam int OFS_RSTEN = 'h08;
    localparam int OFS_COUNT = 'h34;

    // field positions
    localparam int BIT_RUN     = 8;
    localparam int BIT_SRC_SEL = 10;
    localparam int BIT_RATIO   = 16;
    localparam int BIT_EXPIRED = 31;
    localparam int BIT_RSTEN   = 8;

    function automatic logic [BUS_W-1:0] merge_lanes(
        input logic [BUS_W-1:0]  old_v,
        input logic [BUS_W-1:0]  new_v,
        input logic [STRB_W-1:0] strb
    );
        logic [BUS_W-1:0] res;
        res = old_v;
        for (int b = 0; b < STRB_W; b++) begin
            if (strb[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
        end
        return res;
    endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               src_sel_i,
    input  logic               fixed_tick_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);
    localparam int ACC_W = (1 << RATIO_W) - 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic             src_ev;
    logic [ACC_W-1:0] low_mask;

    always_comb begin
        src_ev = src_sel_i ? fixed_tick_i : 1'b1;
        for (int i = 0; i < ACC_W; i++) begin
            low_mask[i] = (32'(i) < 32'(ratio_i));
        end
        tick_o = run_i && src_ev && ((st_q.acc & low_mask) == low_mask);

        st_d = st_q;
        if (!run_i) begin
            st_d.acc = '0;
        end else if (src_ev) begin
            st_d.acc = st_q.acc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        expire_o = tick_i && !load_i && (st_q.cnt == CNT_W'(1));
        st_d = st_q;
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (tick_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        count_o = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{cnt: '1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wdog_periph.sv
module wdog_periph #(
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 32,
    parameter int RATIO_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [wdog_pkg::BUS_W-1:0]    bus_wdata,
    input  logic [wdog_pkg::STRB_W-1:0]   bus_wstrb,
    input  logic                          fixed_tick,
    output logic [wdog_pkg::BUS_W-1:0]    bus_rdata,
    output logic                          irq,
    output logic                          rst_req
);
    import wdog_pkg::*;

    typedef struct packed {
        logic               run;
        logic               src_sel;
        logic [RATIO_W-1:0] ratio;
        logic               rsten;
        logic               expired;
        logic               irq;
        logic [BUS_W-1:0]   rdata;
    } reg_state_t;

    reg_state_t regs_d, regs_q;

    logic             sel_ctrl, sel_stat, sel_rsten, sel_count;
    logic [BUS_W-1:0] ctrl_word, stat_word, rsten_word, count_word;
    logic [BUS_W-1:0] ctrl_new, rsten_new, count_new;
    logic             tick, expire, cnt_load;
    logic [CNT_W-1:0] count, cnt_load_val;

    // observation taps for the checker
    logic st_run, st_rsten, st_expired;
    assign st_run     = regs_q.run;
    assign st_rsten   = regs_q.rsten;
    assign st_expired = regs_q.expired;

    always_comb begin
        sel_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
        sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
        sel_rsten = (bus_addr == ADDR_W'(OFS_RSTEN));
        sel_count = (bus_addr == ADDR_W'(OFS_COUNT));

        ctrl_word = '0;
        ctrl_word[BIT_RUN]               = regs_q.run;
        ctrl_word[BIT_SRC_SEL]           = regs_q.src_sel;
        ctrl_word[BIT_RATIO +: RATIO_W]  = regs_q.ratio;
        stat_word = '0;
        stat_word[BIT_EXPIRED] = regs_q.expired;
        rsten_word = '0;
        rsten_word[BIT_RSTEN] = regs_q.rsten;
        count_word = BUS_W'(count);

        ctrl_new  = merge_lanes(ctrl_word, bus_wdata, bus_wstrb);
        rsten_new = merge_lanes(rsten_word, bus_wdata, bus_wstrb);
        count_new = merge_lanes(count_word, bus_wdata, bus_wstrb);

        cnt_load     = bus_wr && sel_count;
        cnt_load_val = CNT_W'(count_new);
    end

    wdog_prescaler #(.RATIO_W(RATIO_W)) u_pre (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (regs_q.run),
        .src_sel_i    (regs_q.src_sel),
        .fixed_tick_i (fixed_tick),
        .ratio_i      (regs_q.ratio),
        .tick_o       (tick)
    );

    wdog_downcount #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (cnt_load),
        .load_val_i (cnt_load_val),
        .count_o    (count),
        .expire_o   (expire)
    );

    always_comb begin
        regs_d = regs_q;

        if (bus_wr && sel_ctrl) begin
            regs_d.run     = ctrl_new[BIT_RUN];
            regs_d.src_sel = ctrl_new[BIT_SRC_SEL];
            regs_d.ratio   = ctrl_new[BIT_RATIO +: RATIO_W];
        end
        if (bus_wr && sel_rsten) begin
            regs_d.rsten = rsten_new[BIT_RSTEN];
        end
        if (bus_wr && sel_stat && bus_wstrb[BIT_EXPIRED/8] && !bus_wdata[BIT_EXPIRED]) begin
            regs_d.expired = 1'b0;
        end
        if (expire) begin
            regs_d.expired = 1'b1;
        end
        regs_d.irq = expire;

        if (bus_rd) begin
            unique case (1'b1)
                sel_ctrl:  regs_d.rdata = ctrl_word;
                sel_stat:  regs_d.rdata = stat_word;
                sel_rsten: regs_d.rdata = rsten_word;
                sel_count: regs_d.rdata = count_word;
                default:   regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_rdata = regs_q.rdata;
    assign irq       = regs_q.irq;
    assign rst_req   = regs_q.expired && regs_q.run && regs_q.rsten;
endmodule

// File: rtl/wdog_periph_chk.sv
module wdog_periph_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             rst_req,
    input logic             run,
    input logic             rsten,
    input logic             expired,
    input logic             cnt_load,
    input logic [CNT_W-1:0] count
);
    assert_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> expired);

    assert_zero_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !cnt_load) |=> (count == '0));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_load) |=> (count == $past(count)));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_load) |-> (($past(count) - count) <= CNT_W'(1)));

    assert_reset_on_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && run && rsten) |-> rst_req);

    assert_no_reset_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !rst_req);
endmodule

bind wdog_periph wdog_periph_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .rst_req  (rst_req),
    .run      (st_run),
    .rsten    (st_rsten),
    .expired  (st_expired),
    .cnt_load (cnt_load),
    .count    (count)
);

// File: tb/wdog_periph_tb.sv
module wdog_periph_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, fixed_tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int checks = 0, errors = 0, irq_seen = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    wdog_periph u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
        .fixed_tick(fixed_tick), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    // behavioural reference model
    logic [31:0] m_cnt, m_rdata, bm;
    logic        m_run, m_fix, m_rsten, m_exp, m_irq;
    logic [3:0]  m_ratio;
    int          m_pre;
    logic        ev, tk, exp_ev;
    int          dv;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 32'hFFFF_FFFF; m_rdata = 0; m_run = 0; m_fix = 0;
            m_rsten = 0; m_exp = 0; m_irq = 0; m_ratio = 0; m_pre = 0;
        end else begin
            bm = {{8{bus_wstrb[3]}}, {8{bus_wstrb[2]}}, {8{bus_wstrb[1]}}, {8{bus_wstrb[0]}}};
            if (bus_rd) begin
                case (bus_addr)
                    8'h00: m_rdata = (32'(m_run) << 8) | (32'(m_fix) << 10) | (32'(m_ratio) << 16);
                    8'h04: m_rdata = 32'(m_exp) << 31;
                    8'h08: m_rdata = 32'(m_rsten) << 8;
                    8'h34: m_rdata = m_cnt;
                    default: m_rdata = 0;
                endcase
            end
            ev = m_fix ? fixed_tick : 1'b1;
            dv = 1 << m_ratio;
            tk = m_run && ev && ((m_pre % dv) == dv - 1);
            exp_ev = tk && !(bus_wr && bus_addr == 8'h34) && m_cnt == 1;
            m_irq = exp_ev;
            if (bus_wr && bus_addr == 8'h34) m_cnt = (m_cnt & ~bm) | (bus_wdata & bm);
            else if (tk && m_cnt != 0) m_cnt = m_cnt - 1;
            if (!m_run) m_pre = 0;
            else if (ev) m_pre = (m_pre + 1) % 32768;
            if (exp_ev) m_exp = 1;
            else if (bus_wr && bus_addr == 8'h04 && bus_wstrb[3] && !bus_wdata[31]) m_exp = 0;
            if (bus_wr && bus_addr == 8'h00) begin
                if (bus_wstrb[1]) begin m_run = bus_wdata[8]; m_fix = bus_wdata[10]; end
                if (bus_wstrb[2]) m_ratio = bus_wdata[19:16];
            end
            if (bus_wr && bus_addr == 8'h08 && bus_wstrb[1]) m_rsten = bus_wdata[8];
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks += 3;
            if (bus_rdata !== m_rdata) begin
                errors++;
                $display("FAIL R2/%s rdata act=%h exp=%h t=%0t", cur_tag, bus_rdata, m_rdata, $time);
            end
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL R8/%s irq act=%b exp=%b t=%0t", cur_tag, irq, m_irq, $time);
            end
            if (rst_req !== (m_exp && m_run && m_rsten)) begin
                errors++;
                $display("FAIL R10/%s rst_req act=%b exp=%b t=%0t", cur_tag, rst_req,
                         m_exp && m_run && m_rsten, $time);
            end
            if (irq) irq_seen++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_wr = 1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_wr = 0; bus_wstrb = 0;
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_fx(input int n, input int per);
        for (int k = 0; k < n; k++) begin
            fixed_tick = (k % per == 0);
            @(negedge clk);
        end
        fixed_tick = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int base;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        cur_tag = "R1";
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rst_req", 32'(rst_req), 0);
        rd_expect(8'h00, 32'h0, "R1 ctrl");
        rd_expect(8'h04, 32'h0, "R1 status");
        rd_expect(8'h08, 32'h0, "R1 rsten");
        rd_expect(8'h34, 32'hFFFF_FFFF, "R1 count");
        rd_expect(8'h20, 32'h0, "R2 unmapped");

        cur_tag = "R3";
        wr(8'h00, 32'hFFFF_FFFF, 4'b0010);
        rd_expect(8'h00, 32'h0000_0500, "R3 ctrl lane1");
        wr(8'h00, 32'h0003_0000, 4'b0100);
        rd_expect(8'h00, 32'h0003_0500, "R3 ctrl lane2");
        wr(8'h00, 32'h0, 4'b1111);
        wr(8'h34, 32'h1234_5678, 4'b1111);
        wr(8'h34, 32'h0000_00AB, 4'b0001);
        rd_expect(8'h34, 32'h1234_56AB, "R3 count lane0");

        cur_tag = "R4";
        wr(8'h34, 32'd100, 4'b1111);
        wr(8'h00, 32'h0000_0100, 4'b1111);
        idle(9);
        rd_expect(8'h34, 32'd91, "R4 decrement");
        wr(8'h00, 32'h0, 4'b1111);
        idle(5);
        rd_expect(8'h34, 32'd89, "R4 hold when stopped");

        cur_tag = "R5";
        wr(8'h34, 32'd64, 4'b1111);
        wr(8'h00, 32'h0002_0100, 4'b1111);
        idle(8);
        rd_expect(8'h34, 32'd62, "R5 ratio 2");
        wr(8'h00, 32'h0, 4'b1111);

        cur_tag = "R6";
        wr(8'h34, 32'd50, 4'b1111);
        wr(8'h00, 32'h0000_0500, 4'b1111);
        idle(4);
        idle_fx(18, 3);
        rd_expect(8'h34, 32'd44, "R6 fixed source");
        wr(8'h00, 32'h0, 4'b1111);

        cur_tag = "R8";
        base = irq_seen;
        wr(8'h34, 32'd3, 4'b1111);
        wr(8'h00, 32'h0000_0100, 4'b1111);
        idle(10);
        rd_expect(8'h34, 32'd0, "R8 count holds 0");
        rd_expect(8'h04, 32'h8000_0000, "R8 expired flag");
        chk("R8 one irq pulse", 32'(irq_seen - base), 1);
        chk("R10 no reset while disabled", 32'(rst_req), 0);

        cur_tag = "R10";
        wr(8'h08, 32'h0000_0100, 4'b0010);
        chk("R10 rst_req on", 32'(rst_req), 1);
        wr(8'h00, 32'h0, 4'b1111);
        chk("R10 rst_req off by run", 32'(rst_req), 0);
        wr(8'h00, 32'h0000_0100, 4'b1111);
        idle(3);
        chk("R10 rst_req back", 32'(rst_req), 1);
        wr(8'h08, 32'h0, 4'b1111);
        chk("R10 rst_req off by enable", 32'(rst_req), 0);
        wr(8'h00, 32'h0, 4'b1111);

        cur_tag = "R9";
        wr(8'h04, 32'hFFFF_FFFF, 4'b1111);
        rd_expect(8'h04, 32'h8000_0000, "R9 write one keeps");
        wr(8'h04, 32'h0, 4'b0111);
        rd_expect(8'h04, 32'h8000_0000, "R9 lane3 off keeps");
        wr(8'h04, 32'h0, 4'b1000);
        rd_expect(8'h04, 32'h0, "R9 cleared");
        wr(8'h34, 32'd2, 4'b1111);
        wr(8'h00, 32'h0000_0100, 4'b1111);
        idle(1);
        wr(8'h04, 32'h0, 4'b1000);
        rd_expect(8'h04, 32'h8000_0000, "R9 expiry beats clear");
        wr(8'h00, 32'h0, 4'b1111);
        wr(8'h04, 32'h0, 4'b1000);

        cur_tag = "R7";
        base = irq_seen;
        wr(8'h34, 32'd4, 4'b1111);
        wr(8'h00, 32'h0000_0100, 4'b1111);
        for (int k = 0; k < 6; k++) begin
            idle(2);
            wr(8'h34, 32'd4, 4'b1111);
        end
        chk("R7 keep-alive no irq", 32'(irq_seen - base), 0);
        rd_expect(8'h04, 32'h0, "R7 keep-alive no expiry");
        wr(8'h00, 32'h0, 4'b1111);

        cur_tag = "R11";
        base = irq_seen;
        wr(8'h34, 32'd0, 4'b1111);
        wr(8'h00, 32'h0000_0100, 4'b1111);
        idle(10);
        chk("R11 zero load no irq", 32'(irq_seen - base), 0);
        rd_expect(8'h04, 32'h0, "R11 zero load no flag");
        wr(8'h00, 32'h0, 4'b1111);
        idle(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule